// File: doc/BRIEF.md
# GPIO Function-Select and Output-Level Register Block

This block holds the configuration and output state of a bank of 54 general-purpose pins behind a simple 32-bit register bus. Each pin carries a 3-bit function code. The codes are packed ten to a word across six select words. A function code of 1 puts the pin in output mode. Every pin also has a latched level. Software moves that level with write-one-to-set and write-one-to-clear words and reads it back through two level words. A pin's output line follows its latched level only while the pin is in output mode. The block exports every pin's function code, so a neighbouring routing block can decode alternate functions such as a storage-card interface swap.

The bus has separate read and write strobes. A write completes in the cycle it is presented. A read returns its data one cycle later, together with a valid flag. The offsets reserved for edge detection, pull control and event status are present but inert. Any other offset is reported with a one-cycle bad-address pulse.

Top module: `gpio_fsel_regs`

## Requirements
- R1: After reset, every function code is 0, both level words read 0, and all output lines are 0.
- R2: Select word r sits at byte offset 4*r, for r from 0 to 5. Pin 10*r+i is held in bits [3i+2:3i] of that word, and a write replaces all of that word's fields.
- R3: Bits 30 and 31 of every select word read as zero. In select word 5, bits 29 down to 12 also read as zero, because pins 54 and above do not exist.
- R4: Output pin_func carries pin p's code in bits [3p+2:3p]. It changes only in the cycle after a select-word write.
- R5: The set words are at 0x1C (pins 0 to 31) and 0x20 (pins 32 to 53 in bits 21:0). Each 1 bit sets that pin's level, each 0 bit leaves it alone, and a read returns zero.
- R6: The clear words are at 0x28 and 0x2C, with the same pin split as the set words. Each 1 bit clears that pin's level, each 0 bit leaves it alone, and a read returns zero.
- R7: The level words at 0x34 and 0x38 return the latched levels, with the same pin split as the set words and the unused bits of 0x38 reading zero. Writes to them change nothing.
- R8: A set or clear updates the level whatever the pin's mode. Output line p changes only when its function code is 1 at the time of the write and its level actually changes. It then takes the new level. In every other case it holds its value, including when the pin's function code changes.
- R9: Word-aligned offsets from 0x40 to 0x9C read zero, ignore writes, and raise no bad-address pulse.
- R10: Any other offset reads zero and has no effect. This covers a non-word-aligned address, 0x18, 0x24, 0x30, 0x3C and anything above 0x9C. For such an access bad_addr is high for exactly the one cycle that follows the access.
- R11: rd_valid is high for the one cycle after rd_en, and rd_data then holds the value of the addressed word as it stood at the read edge. A write becomes visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | 12 | Byte offset within the register window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | High for the cycle after a read strobe |
| bad_addr | output | 1 | One-cycle pulse after an access to an undefined offset |
| pin_out | output | 54 | Driven level of each pin's output line |
| pin_func | output | 162 | Function code of every pin, 3 bits per pin |

## Verification
All state changes at the clock edge that samples a write strobe. The bench therefore checks pin_out, pin_func and the effect on the levels at the falling edge right after that edge. A read's data, its valid flag and any bad-address pulse all appear one register after the read edge, so the bench samples them at the following falling edge and checks one cycle later that the pulse has dropped. A sweep of select patterns and set/clear masks is checked against a bench-side model. A separate sequence moves pins into and out of output mode to exercise the hold behaviour.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;
  // Fixed offsets of the register window (byte addresses).
  localparam int SEL_BASE = 'h00;
  localparam int SET_BASE = 'h1C;
  localparam int CLR_BASE = 'h28;
  localparam int LEV_BASE = 'h34;
  localparam int INERT_LO = 'h40;
  localparam int INERT_HI = 'h9C;

  typedef enum logic [2:0] {
    ACC_BAD   = 3'd0,
    ACC_SEL   = 3'd1,
    ACC_SET   = 3'd2,
    ACC_CLR   = 3'd3,
    ACC_LEV   = 3'd4,
    ACC_INERT = 3'd5
  } acc_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_fsel_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SEL   = 6,
  parameter int NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [2:0]        idx
);
  int a;

  always_comb begin
    kind = ACC_BAD;
    idx  = '0;
    a    = 32'(addr);
    if (addr[1:0] == 2'b00) begin
      for (int r = 0; r < NUM_SEL; r++) begin
        if (a == SEL_BASE + 4*r) begin
          kind = ACC_SEL;
          idx  = 3'(r);
        end
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (a == SET_BASE + 4*b) begin
          kind = ACC_SET;
          idx  = 3'(b);
        end
        if (a == CLR_BASE + 4*b) begin
          kind = ACC_CLR;
          idx  = 3'(b);
        end
        if (a == LEV_BASE + 4*b) begin
          kind = ACC_LEV;
          idx  = 3'(b);
        end
      end
      if (a >= INERT_LO && a <= INERT_HI) kind = ACC_INERT;
    end
  end
endmodule

// File: rtl/gpio_fsel_store.sv
module gpio_fsel_store #(
  parameter int NUM_PINS = 54,
  parameter int CODE_W   = 3,
  parameter int PER_WORD = 10,
  parameter int DATA_W   = 32,
  parameter int OUT_CODE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [2:0]                 idx,
  input  logic [DATA_W-1:0]          wr_word,
  output logic [DATA_W-1:0]          rd_word,
  output logic [NUM_PINS-1:0]        is_out,
  output logic [NUM_PINS*CODE_W-1:0] codes_flat
);
  logic [NUM_PINS-1:0][CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_stb && idx == 3'(p / PER_WORD))
          code_q[p] <= wr_word[CODE_W*(p % PER_WORD) +: CODE_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < PER_WORD; i++) begin
      if (int'(idx) * PER_WORD + i < NUM_PINS)
        rd_word[CODE_W*i +: CODE_W] = code_q[int'(idx) * PER_WORD + i];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign is_out[p] = (code_q[p] == CODE_W'(OUT_CODE));
    assign codes_flat[CODE_W*p +: CODE_W] = code_q[p];
  end

  // R4
  func_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(codes_flat));
endmodule

// File: rtl/gpio_level_latch.sv
module gpio_level_latch #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_stb,
  input  logic                clr_stb,
  input  logic [2:0]          idx,
  input  logic [DATA_W-1:0]   wr_word,
  input  logic [NUM_PINS-1:0] is_out,
  output logic [DATA_W-1:0]   rd_word,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] pin_out
);
  logic [NUM_PINS-1:0] lev_q, out_q, set_m, clr_m, lev_nxt;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (idx == 3'(p / DATA_W) && wr_word[p % DATA_W]) begin
        set_m[p] = set_stb;
        clr_m[p] = clr_stb;
      end
    end
    lev_nxt = (lev_q | set_m) & ~clr_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lev_q <= '0;
      out_q <= '0;
    end else begin
      lev_q <= lev_nxt;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (is_out[p] && lev_nxt[p] != lev_q[p]) out_q[p] <= lev_nxt[p];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int o = 0; o < DATA_W; o++) begin
      if (int'(idx) * DATA_W + o < NUM_PINS)
        rd_word[o] = lev_q[int'(idx) * DATA_W + o];
    end
  end

  assign level   = lev_q;
  assign pin_out = out_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    // R8
    out_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q[p] != $past(out_q[p])) |-> $past(is_out[p]));
    // R8
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q[p] != $past(out_q[p])) |-> (out_q[p] == lev_q[p]));
  end
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_fsel_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int CODE_W   = 3,
  parameter int PER_WORD = 10,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int OUT_CODE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic                       bad_addr,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS*CODE_W-1:0] pin_func
);
  localparam int NUM_SEL   = (NUM_PINS + PER_WORD - 1) / PER_WORD;
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

  acc_kind_e           kind;
  logic [2:0]          idx;
  logic [DATA_W-1:0]   sel_word, lev_word, rd_q;
  logic [NUM_PINS-1:0] is_out, level;
  logic                valid_q, bad_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(addr), .kind(kind), .idx(idx)
  );

  gpio_fsel_store #(
    .NUM_PINS(NUM_PINS), .CODE_W(CODE_W), .PER_WORD(PER_WORD),
    .DATA_W(DATA_W), .OUT_CODE(OUT_CODE)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_en && kind == ACC_SEL), .idx(idx),
    .wr_word(wr_data), .rd_word(sel_word), .is_out(is_out), .codes_flat(pin_func)
  );

  gpio_level_latch #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_lev (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_en && kind == ACC_SET), .clr_stb(wr_en && kind == ACC_CLR),
    .idx(idx), .wr_word(wr_data), .is_out(is_out), .rd_word(lev_word),
    .level(level), .pin_out(pin_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      valid_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      valid_q <= rd_en;
      bad_q   <= (rd_en || wr_en) && kind == ACC_BAD;
      if (rd_en) begin
        case (kind)
          ACC_SEL: rd_q <= sel_word;
          ACC_LEV: rd_q <= lev_word;
          default: rd_q <= '0;
        endcase
      end
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = valid_q;
  assign bad_addr = bad_q;

  // R7
  lev_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == ACC_LEV) |=> (level == $past(level)));
  // R10
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(rd_en || wr_en));
  // R3
  sel_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(kind == ACC_SEL)) |-> (rd_data[DATA_W-1:CODE_W*PER_WORD] == '0));
  // R9
  inert_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(kind == ACC_INERT)) |-> (rd_data == '0 && !bad_addr));
endmodule

// File: tb/test_gpio_fsel_regs.sv
module test_gpio_fsel_regs;
  localparam int N = 54;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic rd_valid, bad_addr;
  logic [N-1:0] pin_out;
  logic [3*N-1:0] pin_func;

  int total = 0, fails = 0;
  bit done = 0;

  logic [2:0] mf [N];
  logic [N-1:0] ml, mo;

  always #2 clk = ~clk;

  gpio_fsel_regs i_gpio_fsel_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .bad_addr(bad_addr), .pin_out(pin_out), .pin_func(pin_func)
  );

  task automatic chk(input string req, input logic [199:0] act, input logic [199:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 12'(a); wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic bad, output logic vld);
    @(negedge clk);
    addr = 12'(a); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; bad = bad_addr; vld = rd_valid;
  endtask

  function automatic logic [31:0] exp_sel(input int r);
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) if (10*r + i < N) w[3*i +: 3] = mf[10*r + i];
    return w;
  endfunction

  function automatic logic [31:0] exp_lev(input int b);
    logic [31:0] w = '0;
    for (int o = 0; o < 32; o++) if (32*b + o < N) w[o] = ml[32*b + o];
    return w;
  endfunction

  function automatic logic [3*N-1:0] exp_func();
    logic [3*N-1:0] v;
    for (int p = 0; p < N; p++) v[3*p +: 3] = mf[p];
    return v;
  endfunction

  task automatic wr_sel(input int r, input logic [31:0] w);
    wr(4*r, w);
    for (int i = 0; i < 10; i++) if (10*r + i < N) mf[10*r + i] = w[3*i +: 3];
  endtask

  task automatic lev_op(input int b, input logic [31:0] m, input bit is_clr);
    wr((is_clr ? 'h28 : 'h1C) + 4*b, m);
    for (int o = 0; o < 32; o++) begin
      if (32*b + o < N && m[o]) begin
        int p = 32*b + o;
        logic nv = !is_clr;
        if (mf[p] == 3'd1 && ml[p] != nv) mo[p] = nv;
        ml[p] = nv;
      end
    end
    chk(is_clr ? "R6 pin_out" : "R5 pin_out", 200'(pin_out), 200'(mo));
  endtask

  task automatic check_state(input string req);
    logic [31:0] d; logic bad, vld;
    for (int r = 0; r < 6; r++) begin
      rd(4*r, d, bad, vld);
      chk(req, 200'(d), 200'(exp_sel(r)));
    end
    for (int b = 0; b < 2; b++) begin
      rd('h34 + 4*b, d, bad, vld);
      chk(req, 200'(d), 200'(exp_lev(b)));
    end
    chk(req, 200'(pin_out), 200'(mo));
    chk(req, 200'(pin_func), 200'(exp_func()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic bad, vld;
    for (int p = 0; p < N; p++) mf[p] = 3'd0;
    ml = '0; mo = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_state("R1 reset");

    // R2 R4 select packing sweep, garbage in pad bits
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 6; r++) begin
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++) w[3*i +: 3] = 3'((10*r + i)*5 + k*3);
        w[31:30] = 2'(k);
        wr_sel(r, w);
        chk("R4 pin_func after write", 200'(pin_func), 200'(exp_func()));
      end
      check_state("R2 select readback");
    end

    // R3 unimplemented select bits read zero
    wr_sel(0, 32'hFFFF_FFFF);
    rd(0, d, bad, vld);
    chk("R3 word0 pad", 200'(d), 200'(32'h3FFF_FFFF));
    wr_sel(5, 32'hFFFF_FFFF);
    rd('h14, d, bad, vld);
    chk("R3 word5 pad", 200'(d), 200'(32'h0000_0FFF));

    // R11 read valid timing and one-cycle width
    rd('h14, d, bad, vld);
    chk("R11 rd_valid", 200'(vld), 200'(1));
    @(negedge clk);
    chk("R11 rd_valid drop", 200'(rd_valid), 200'(0));

    // mixed modes: codes 1,0,4,1 repeating
    for (int r = 0; r < 6; r++) begin
      logic [31:0] w = '0;
      for (int i = 0; i < 10; i++) begin
        int p = 10*r + i;
        w[3*i +: 3] = (p % 4 == 1) ? 3'd0 : (p % 4 == 2) ? 3'd4 : 3'd1;
      end
      wr_sel(r, w);
    end

    // R5 R6 R8 set/clear sweep
    for (int t = 0; t < 12; t++) begin
      logic [31:0] m = (32'hA5C3_96F1 >> t) ^ (32'(t) * 32'h0101_0101);
      lev_op(t % 2, m, 1'b0);
      lev_op((t + 1) % 2, m ^ 32'h3C3C_C3C3, 1'b1);
      check_state("R8 level sweep");
    end
    rd('h1C, d, bad, vld); chk("R5 set read zero", 200'(d), 200'(0));
    rd('h20, d, bad, vld); chk("R5 set read zero", 200'(d), 200'(0));
    rd('h28, d, bad, vld); chk("R6 clr read zero", 200'(d), 200'(0));
    rd('h2C, d, bad, vld); chk("R6 clr read zero", 200'(d), 200'(0));
    lev_op(0, 32'h0, 1'b0);
    lev_op(1, 32'h0, 1'b1);
    check_state("R5 R6 zero bits no effect");

    // R8 hold: all to input, toggle levels, back to output
    for (int r = 0; r < 6; r++) wr_sel(r, 32'h0);
    lev_op(0, 32'hFFFF_FFFF, 1'b0);
    lev_op(1, 32'h003F_FFFF, 1'b0);
    lev_op(0, 32'h0000_FFFF, 1'b1);
    for (int r = 0; r < 6; r++) wr_sel(r, 32'h0924_9249);
    check_state("R8 mode change holds outputs");
    lev_op(0, 32'hFFFF_FFFF, 1'b0);
    lev_op(1, 32'h003F_FFFF, 1'b0);
    check_state("R8 set on outputs");
    lev_op(0, 32'hFFFF_FFFF, 1'b1);
    lev_op(1, 32'h003F_FFFF, 1'b1);
    check_state("R8 clear on outputs");
    lev_op(1, 32'h002A_AAAA, 1'b0);
    check_state("R8 bank1 set");

    // R7 level words ignore writes
    wr('h34, 32'hFFFF_FFFF);
    wr('h38, 32'hFFFF_FFFF);
    check_state("R7 level write ignored");

    // R9 inert offsets
    for (int a = 'h40; a <= 'h9C; a += 4) begin
      wr(a, 32'hFFFF_FFFF);
      chk("R9 inert write no pulse", 200'(bad_addr), 200'(0));
      rd(a, d, bad, vld);
      chk("R9 inert read", 200'({bad, d}), 200'({1'b0, 32'h0}));
    end
    check_state("R9 inert no effect");

    // R10 bad offsets
    foreach (mf[q]) begin end
    for (int j = 0; j < 9; j++) begin
      int a = (j == 0) ? 'h18 : (j == 1) ? 'h24 : (j == 2) ? 'h30 : (j == 3) ? 'h3C :
              (j == 4) ? 'hA0 : (j == 5) ? 'h2 : (j == 6) ? 'h1D : (j == 7) ? 'h101 : 'hFFC;
      wr(a, 32'hFFFF_FFFF);
      chk("R10 write pulse", 200'(bad_addr), 200'(1));
      @(negedge clk);
      chk("R10 pulse one cycle", 200'(bad_addr), 200'(0));
      rd(a, d, bad, vld);
      chk("R10 read zero with pulse", 200'({bad, d}), 200'({1'b1, 32'h0}));
    end
    check_state("R10 bad access no effect");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule